// File: doc/BRIEF.md
# Serial Master Register Front End

This block is the software-facing half of a synchronous serial master. It decodes a word-addressed register bus and holds the control, clock-prescale and interrupt-mask settings. It also keeps two eight-entry queues of 16-bit words: one queue carries words toward the shift engine and the other carries words back from it. A separate transfer engine takes outbound words through a valid/ready pop port and delivers inbound words through a valid/ready push port. That exchange is allowed only while the enable bit of the second control register is set.

The queue occupancies drive the status register directly, along with the level-triggered interrupt sources and the single interrupt line. The low nibble of the first control register selects a word width from 1 to 16 bits. Every word entering either queue is trimmed to that width. A data write to a full outbound queue is lost. A data read from an empty inbound queue returns zero and changes nothing.

Top module: `spi_ctl_front`

## Requirements
- R1: After synchronous reset, the registers read as follows: status 0x03, raw interrupt 0x08, mask 0, masked interrupt 0, control 0, control 1, prescale and data all 0. The irq output is low.
- R2: Control 0 keeps the low 16 bits written. Its bits [3:0] give n, and every word pushed into either queue is ANDed with (1<<(n+1))-1.
- R3: A write to data (0x08) enters the outbound queue only while that queue holds fewer than 8 words. Otherwise the write is discarded, and the words already queued stay in order.
- R4: A read of data returns the oldest inbound word and removes it. When the inbound queue is empty, the read returns 0 and removes nothing.
- R5: Status (0x0C) has these bits: bit0 is set when the outbound queue is empty, bit1 when it is not full, bit2 when the inbound queue is not empty, bit3 when the inbound queue holds 8 words, and bit4 (busy) when the outbound queue holds any word.
- R6: Raw interrupt (0x18) has bit2 set when the inbound queue holds 4 or more words and bit3 set when the outbound queue holds 4 or fewer words. All other bits are 0.
- R7: The mask (0x14) keeps bits [3:0]. Masked interrupt (0x1C) reads raw AND mask, and irq is high exactly when that AND is nonzero.
- R8: Prescale (0x10) keeps only the low 8 bits written. Control 1 (0x04) keeps bits [3:0], and bit1 is the transfer enable.
- R9: tx_pop_valid is high only when enable is set and the outbound queue is not empty. tx_pop_data is the oldest outbound word. rx_push_ready is high only when enable is set and the inbound queue holds fewer than 8 words.
- R10: Offsets outside the map and the read-only offsets (status, raw, masked) ignore writes. Unmapped offsets and 0x20 read as 0.
- R11: A data write and an engine pop in the same cycle both take effect, as do a data read and an engine push. Word order is kept in both queues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Combined interrupt |
| tx_pop_valid | output | 1 | Outbound word available to engine |
| tx_pop_ready | input | 1 | Engine takes the outbound word |
| tx_pop_data | output | 16 | Oldest outbound word |
| rx_push_valid | input | 1 | Engine offers an inbound word |
| rx_push_ready | output | 1 | Inbound word accepted |
| rx_push_data | input | 16 | Inbound word |

## Verification
A bus data write can land in the same cycle as an engine pop from the outbound queue. A bus data read can land in the same cycle as an engine push into the inbound queue. Either pairing can coincide with a full or empty boundary. The bench runs the engine handshake in a parallel thread with ready and valid held high while the bus alternates data writes and reads every cycle. A queue-based model applies the pop before the push and takes full and empty from the occupancy before the edge. On every clock the model is compared with the handshake outputs and irq, and on every read with the returned word.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

    localparam int BUS_W  = 32;
    localparam int WORD_W = 16;
    localparam int NSEL_W = $clog2(WORD_W);
    localparam int CR1_W  = 4;
    localparam int PSC_W  = 8;
    localparam int IRQ_W  = 4;
    localparam int EN_BIT = 1;

    typedef enum logic [3:0] {
        SEL_CTL0, SEL_CTL1, SEL_DATA, SEL_STAT, SEL_PSC,
        SEL_MASK, SEL_RAW, SEL_MIS, SEL_DMA, SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic busy;
        logic rx_full;
        logic rx_nempty;
        logic tx_nfull;
        logic tx_empty;
    } stat_t;

    function automatic reg_sel_e decode_addr(input logic [31:0] a);
        case (a)
            32'h00:  return SEL_CTL0;
            32'h04:  return SEL_CTL1;
            32'h08:  return SEL_DATA;
            32'h0C:  return SEL_STAT;
            32'h10:  return SEL_PSC;
            32'h14:  return SEL_MASK;
            32'h18:  return SEL_RAW;
            32'h1C:  return SEL_MIS;
            32'h20:  return SEL_DMA;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] width_mask(input logic [NSEL_W-1:0] n);
        logic [31:0] ones;
        ones = (32'd1 << (32'(n) + 32'd1)) - 32'd1;
        return ones[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/spi_ctl_fifo.sv
module spi_ctl_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head_data = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // R3: occupancy never exceeds depth; a push into a full queue is lost
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (count == CW'(DEPTH) && push && !pop) |=> count == CW'(DEPTH));
    a_r3_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    // R4: popping an empty queue leaves it empty
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && pop && !push) |=> count == '0);
    // R11: simultaneous accepted push and pop keep occupancy
    a_r11_balance: assert property (@(posedge clk) disable iff (rst)
        (push && pop && count != '0 && count != CW'(DEPTH)) |=> $stable(count));

endmodule

// File: rtl/spi_ctl_flags.sv
module spi_ctl_flags
    import spi_ctl_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int HALF = DEPTH / 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CW-1:0]    tx_cnt,
    input  logic [CW-1:0]    rx_cnt,
    input  logic [IRQ_W-1:0] mask,
    output stat_t            stat,
    output logic [IRQ_W-1:0] raw,
    output logic [IRQ_W-1:0] masked,
    output logic             irq
);

    always_comb begin
        stat.tx_empty  = (tx_cnt == '0);
        stat.tx_nfull  = (tx_cnt != CW'(DEPTH));
        stat.rx_nempty = (rx_cnt != '0);
        stat.rx_full   = (rx_cnt == CW'(DEPTH));
        stat.busy      = (tx_cnt != '0);
        raw            = '0;
        raw[2]         = (rx_cnt >= CW'(HALF));
        raw[3]         = (tx_cnt <= CW'(HALF));
        masked         = raw & mask;
        irq            = |masked;
    end

    // R6: a full inbound queue always asserts the receive-level source
    a_r6_full_rx_level: assert property (@(posedge clk) disable iff (rst)
        stat.rx_full |-> raw[2]);
    // R6: an empty outbound queue always asserts the transmit-level source
    a_r6_empty_tx_level: assert property (@(posedge clk) disable iff (rst)
        stat.tx_empty |-> raw[3]);

endmodule

// File: rtl/spi_ctl_front.sv
module spi_ctl_front
    import spi_ctl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq,
    output logic              tx_pop_valid,
    input  logic              tx_pop_ready,
    output logic [WORD_W-1:0] tx_pop_data,
    input  logic              rx_push_valid,
    output logic              rx_push_ready,
    input  logic [WORD_W-1:0] rx_push_data
);

    logic [WORD_W-1:0] ctl0_q;
    logic [CR1_W-1:0]  ctl1_q;
    logic [PSC_W-1:0]  psc_q;
    logic [IRQ_W-1:0]  mask_q;

    reg_sel_e          sel;
    logic              wr_hit, rd_hit;
    logic              en;
    logic [WORD_W-1:0] wmask, rx_head;
    logic [CW-1:0]     tx_cnt, rx_cnt;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    stat_t             stat;
    logic [IRQ_W-1:0]  raw, masked;
    logic              unused_hi;

    assign unused_hi = ^bus_wdata[BUS_W-1:WORD_W];

    assign sel    = decode_addr(32'(bus_addr));
    assign wr_hit = bus_sel && bus_wr;
    assign rd_hit = bus_sel && !bus_wr;
    assign en     = ctl1_q[EN_BIT];
    assign wmask  = width_mask(ctl0_q[NSEL_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl0_q <= '0;
            ctl1_q <= '0;
            psc_q  <= '0;
            mask_q <= '0;
        end else if (wr_hit) begin
            case (sel)
                SEL_CTL0: ctl0_q <= bus_wdata[WORD_W-1:0];
                SEL_CTL1: ctl1_q <= bus_wdata[CR1_W-1:0];
                SEL_PSC:  psc_q  <= bus_wdata[PSC_W-1:0];
                SEL_MASK: mask_q <= bus_wdata[IRQ_W-1:0];
                default:  ;
            endcase
        end
    end

    spi_ctl_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
        .clk       (clk),
        .rst       (rst),
        .push      (wr_hit && sel == SEL_DATA),
        .push_data (bus_wdata[WORD_W-1:0] & wmask),
        .pop       (tx_pop_valid && tx_pop_ready),
        .head_data (tx_pop_data),
        .count     (tx_cnt),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    spi_ctl_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .push      (rx_push_valid && rx_push_ready),
        .push_data (rx_push_data & wmask),
        .pop       (rd_hit && sel == SEL_DATA),
        .head_data (rx_head),
        .count     (rx_cnt),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    assign tx_pop_valid  = en && !tx_empty;
    assign rx_push_ready = en && !rx_full;

    spi_ctl_flags #(.DEPTH(DEPTH)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .tx_cnt (tx_cnt),
        .rx_cnt (rx_cnt),
        .mask   (mask_q),
        .stat   (stat),
        .raw    (raw),
        .masked (masked),
        .irq    (irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_CTL0: bus_rdata = BUS_W'(ctl0_q);
            SEL_CTL1: bus_rdata = BUS_W'(ctl1_q);
            SEL_DATA: bus_rdata = rx_empty ? '0 : BUS_W'(rx_head);
            SEL_STAT: bus_rdata = BUS_W'(stat);
            SEL_PSC:  bus_rdata = BUS_W'(psc_q);
            SEL_MASK: bus_rdata = BUS_W'(mask_q);
            SEL_RAW:  bus_rdata = BUS_W'(raw);
            SEL_MIS:  bus_rdata = BUS_W'(masked);
            default:  bus_rdata = '0;
        endcase
    end

    // R9: with the enable clear, only a bus read can change inbound occupancy
    a_r9_no_push_disabled: assert property (@(posedge clk) disable iff (rst)
        (!en && !(rd_hit && sel == SEL_DATA)) |=> rx_cnt == $past(rx_cnt));
    // R9: with the enable clear, outbound occupancy never falls
    a_r9_no_pop_disabled: assert property (@(posedge clk) disable iff (rst)
        !en |=> tx_cnt >= $past(tx_cnt));
    // R10: writes to unmapped offsets leave every setting unchanged
    a_r10_ignore_unmapped: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && sel == SEL_NONE) |=>
            ($stable(ctl0_q) && $stable(ctl1_q) && $stable(psc_q) && $stable(mask_q)));

endmodule

// File: tb/spi_ctl_front_tb.sv
module spi_ctl_front_tb;

    logic        clk = 0;
    logic        rst = 1;
    logic        bus_sel = 0, bus_wr = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, tx_pop_valid, rx_push_ready;
    logic        tx_pop_ready = 0, rx_push_valid = 0;
    logic [15:0] tx_pop_data, rx_push_data = '0;

    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    spi_ctl_front u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .tx_pop_valid(tx_pop_valid), .tx_pop_ready(tx_pop_ready),
        .tx_pop_data(tx_pop_data), .rx_push_valid(rx_push_valid),
        .rx_push_ready(rx_push_ready), .rx_push_data(rx_push_data)
    );

    // behavioural reference state
    int m_ctl0, m_ctl1, m_psc, m_mask;
    int txq[$];
    int rxq[$];

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int m_stat();
        int s = 0;
        if (txq.size() == 0) s |= 1;
        if (txq.size() != 8) s |= 2;
        if (rxq.size() != 0) s |= 4;
        if (rxq.size() == 8) s |= 8;
        if (txq.size() != 0) s |= 16;
        return s;
    endfunction

    function automatic int m_raw();
        int r = 0;
        if (rxq.size() >= 4) r |= 4;
        if (txq.size() <= 4) r |= 8;
        return r;
    endfunction

    function automatic int exp_rd(int a);
        case (a)
            'h00: return m_ctl0;
            'h04: return m_ctl1;
            'h08: return (rxq.size() > 0) ? rxq[0] : 0;
            'h0C: return m_stat();
            'h10: return m_psc;
            'h14: return m_mask;
            'h18: return m_raw();
            'h1C: return m_raw() & m_mask;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        bit en, popt, pusht, pushr, popr;
        int msk;
        if (rst) begin
            txq.delete(); rxq.delete();
            m_ctl0 = 0; m_ctl1 = 0; m_psc = 0; m_mask = 0;
        end else begin
            en    = m_ctl1[1];
            msk   = (1 << ((m_ctl0 & 15) + 1)) - 1;
            popt  = tx_pop_ready && en && txq.size() > 0;
            pusht = bus_sel && bus_wr && bus_addr == 12'h008 && txq.size() < 8;
            pushr = rx_push_valid && en && rxq.size() < 8;
            popr  = bus_sel && !bus_wr && bus_addr == 12'h008 && rxq.size() > 0;
            if (popt)  void'(txq.pop_front());
            if (popr)  void'(rxq.pop_front());
            if (pusht) txq.push_back(int'(bus_wdata) & msk);
            if (pushr) rxq.push_back(int'(rx_push_data) & msk);
            if (bus_sel && bus_wr) begin
                case (bus_addr)
                    12'h000: m_ctl0 = int'(bus_wdata) & 'hFFFF;
                    12'h004: m_ctl1 = int'(bus_wdata) & 'hF;
                    12'h010: m_psc  = int'(bus_wdata) & 'hFF;
                    12'h014: m_mask = int'(bus_wdata) & 'hF;
                    default: ;
                endcase
            end
        end
    end

    // per-clock comparison of state-driven outputs
    always @(negedge clk) begin
        if (!rst) begin
            chk("R7 irq", int'(irq), ((m_raw() & m_mask) != 0) ? 1 : 0);
            chk("R9 tx_pop_valid", int'(tx_pop_valid),
                (m_ctl1[1] && txq.size() > 0) ? 1 : 0);
            if (tx_pop_valid && txq.size() > 0)
                chk("R11 tx_pop_data order", int'(tx_pop_data), txq[0]);
            chk("R9 rx_push_ready", int'(rx_push_ready),
                (m_ctl1[1] && rxq.size() < 8) ? 1 : 0);
        end
    end

    task automatic bus(bit w, int a, int d, string tag);
        @(negedge clk);
        bus_sel = 1; bus_wr = w; bus_addr = 12'(a); bus_wdata = d;
        #4;
        if (!w) chk(tag, int'(bus_rdata), exp_rd(a));
        @(posedge clk);
        #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd_const(int a, int exp, string tag);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = 12'(a);
        #4;
        chk(tag, int'(bus_rdata), exp);
        @(posedge clk);
        #1;
        bus_sel = 0;
    endtask

    task automatic engine(int n, bit rdy, bit vld, int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tx_pop_ready  = rdy;
            rx_push_valid = vld;
            rx_push_data  = 16'(seed + i * 'h1111);
        end
        @(negedge clk);
        tx_pop_ready = 0; rx_push_valid = 0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset values
        rd_const('h0C, 'h03, "R1 status");
        rd_const('h18, 'h08, "R1 raw");
        rd_const('h14, 0, "R1 mask");
        rd_const('h1C, 0, "R1 masked");
        rd_const('h00, 0, "R1 ctl0");
        rd_const('h04, 0, "R1 ctl1");
        rd_const('h10, 0, "R1 psc");
        rd_const('h08, 0, "R4 empty read");
        chk("R1 irq", int'(irq), 0);

        // R2, R8 register fields
        bus(1, 'h00, 'h1234FFF7, "");
        rd_const('h00, 'hFFF7, "R2 ctl0 readback");
        bus(1, 'h10, 'h1A5, "");
        rd_const('h10, 'hA5, "R8 psc low byte");
        bus(1, 'h04, 'hF5, "");
        rd_const('h04, 'h5, "R8 ctl1 nibble");

        // R10 unmapped and read-only offsets
        bus(1, 'h24, 'hFFFF, "");
        bus(1, 'h0C, 'hFFFF, "");
        bus(1, 'h18, 'hFFFF, "");
        bus(1, 'h1C, 'hFFFF, "");
        bus(1, 'h20, 'hFFFF, "");
        rd_const('h24, 0, "R10 unmapped read");
        rd_const('h20, 0, "R10 dma read");
        rd_const('h0C, 'h03, "R10 status unchanged");
        rd_const('h00, 'hFFF7, "R10 ctl0 unchanged");

        // R3 fill beyond depth while disabled
        for (int i = 0; i < 10; i++) bus(1, 'h08, 'h1230 + i, "");
        rd_const('h0C, 'h10, "R5 tx full status");
        rd_const('h18, 'h00, "R6 raw with tx full");
        chk("R9 no pop when disabled", int'(tx_pop_valid), 0);

        // R7 mask
        bus(1, 'h14, 'hFF, "");
        rd_const('h14, 'hF, "R7 mask nibble");

        // enable and drain through engine; inbound fills
        bus(1, 'h04, 'h2, "");
        @(negedge clk);
        chk("R2 first word trimmed", int'(tx_pop_data), 'h30);
        engine(12, 1, 1, 'hABCD);
        rd_const('h0C, 'h0F, "R5 tx empty rx full");
        rd_const('h18, 'h0C, "R6 both levels");
        rd_const('h1C, 'h0C, "R7 masked");
        chk("R7 irq high", int'(irq), 1);
        rd_const('h08, 'hCD, "R4 oldest inbound trimmed");
        for (int i = 0; i < 8; i++) bus(0, 'h08, 0, "R4 data read");
        rd_const('h0C, 'h03, "R5 both empty");

        // R3: word 0x38/0x39 must not have been sent: check via R11 order above
        // R11 concurrency: engine runs while bus writes and reads alternate
        fork
            engine(24, 1, 1, 'h1357);
            begin
                for (int i = 0; i < 10; i++) begin
                    bus(1, 'h08, 'h5A0 + i, "");
                    bus(0, 'h08, 0, "R11 concurrent read");
                end
            end
        join
        for (int i = 0; i < 10; i++) bus(0, 'h08, 0, "R11 drain read");
        engine(10, 1, 0, 0);

        // R9 disabled: words stay queued
        bus(1, 'h04, 'h0, "");
        bus(1, 'h00, 'hF, "");
        bus(1, 'h08, 'hBEEF, "");
        bus(1, 'h00, 'h3, "");
        bus(1, 'h08, 'hBEEF, "");
        engine(4, 1, 1, 'h7777);
        chk("R9 held while disabled", int'(tx_pop_valid), 0);
        rd_const('h0C, 'h12, "R5 busy with two words");
        rd_const('h08, 0, "R9 no inbound while disabled");
        bus(1, 'h04, 'h2, "");
        @(negedge clk);
        chk("R2 full width word", int'(tx_pop_data), 'hBEEF);
        engine(1, 1, 0, 0);
        chk("R2 four bit word", int'(tx_pop_data), 'hF);
        engine(3, 1, 0, 0);
        rd_const('h0C, 'h03, "R5 drained");
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule